// File: doc/BRIEF.md
# Periodic DMA Time-Slice Arbiter

This block sits in front of the internal fetch engine of a USB device controller. In each (micro)frame it decides whether the engine works for periodic IN endpoints or for non-periodic endpoints. A start-of-frame pulse restarts a cycle counter. The counter's limit is a full-speed frame or a high-speed microframe, chosen by a speed input.

When scatter/gather operation is enabled and at least one periodic endpoint is active, periodic requests have priority until a programmed share of the (micro)frame has elapsed. After that point non-periodic requests have priority. If no periodic endpoint is active, non-periodic traffic has priority for the whole (micro)frame. In any other operating mode the two classes alternate in plain round-robin, with no time budget. A burst-active input freezes the grant, so ownership only moves between transfers.

Top module: `pdma_slice_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant` is 2'b00 and `elapsed` is 0.
- R2: When `sof` is sampled high, `elapsed` reads 0 in the next cycle. Otherwise `elapsed` rises by one per clock and holds at frame length minus 1. The frame length is FRAME_HS when `hs_mode`=1 and FRAME_FS when `hs_mode`=0.
- R3: `budget_sel` sets the periodic window length. 2'b00 gives floor(L/4), 2'b01 gives floor(L/2) and 2'b10 gives floor(L/2)+floor(L/4), where L is the frame length. The window is open while `elapsed` is below this threshold.
- R4: The reserved code `budget_sel`=2'b11 gives the same window as 2'b00.
- R5: With `sg_mode`=1 and `per_active`=1, inside the window the periodic class is granted whenever `per_req` is high. The non-periodic class is granted only when `per_req` is low.
- R6: With `sg_mode`=1 and `per_active`=1, outside the window the non-periodic class is granted whenever `np_req` is high. The periodic class is granted only when `np_req` is low.
- R7: With `sg_mode`=1 and `per_active`=0, the non-periodic class has priority for the whole (micro)frame, whatever `budget_sel` holds.
- R8: With `sg_mode`=0 and both classes requesting, the grant alternates between the classes on every decision, whatever the window state.
- R9: While `burst_act` is high, `grant` keeps its value.
- R10: `grant` is registered, one cycle after the inputs it is decided from. Bit 0 marks the periodic class, bit 1 marks the non-periodic class, and 2'b00 means no grant. At most one bit is ever set, and with no request and no burst the grant is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-(micro)frame pulse |
| hs_mode | input | 1 | 1: microframe length, 0: full-speed frame length |
| budget_sel | input | 2 | Periodic share: 00 25%, 01 50%, 10 75%, 11 as 00 |
| sg_mode | input | 1 | 1: scatter/gather operation, time budget in force |
| per_active | input | 1 | At least one periodic endpoint is active |
| per_req | input | 1 | Periodic IN fetch request |
| np_req | input | 1 | Non-periodic fetch request |
| burst_act | input | 1 | A transfer is in progress; hold the grant |
| grant | output | 2 | One-hot grant: bit 0 periodic, bit 1 non-periodic |
| elapsed | output | $clog2(max(FRAME_HS,FRAME_FS)) | Cycles since the last start-of-frame |
| in_window | output | 1 | Periodic priority window is open |

## Verification
Two events can fall on the same clock edge: the release of a held burst and a start-of-frame that restarts the counter. The bench provokes this by holding a periodic burst past the window and then dropping `burst_act` and raising `sof` on the same cycle. The first free decision must use the old, closed-window count and therefore grant the non-periodic class. The decision after it must see the fresh count of 0 and give the periodic class back its priority.

// File: rtl/pdma_slice_arb.sv
module pdma_slice_arb #(
  parameter int FRAME_HS = 7500,
  parameter int FRAME_FS = 60000,
  localparam int LMAX = (FRAME_HS > FRAME_FS) ? FRAME_HS : FRAME_FS,
  localparam int CW = $clog2(LMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          hs_mode,
  input  logic [1:0]    budget_sel,
  input  logic          sg_mode,
  input  logic          per_active,
  input  logic          per_req,
  input  logic          np_req,
  input  logic          burst_act,
  output logic [1:0]    grant,
  output logic [CW-1:0] elapsed,
  output logic          in_window
);

  localparam logic [1:0] G_NONE = 2'b00;
  localparam logic [1:0] G_PER  = 2'b01;
  localparam logic [1:0] G_NP   = 2'b10;

  logic [CW:0] frame_len, quarter, half, thresh;
  logic [1:0]  nxt_grant;
  logic        np_last;

  assign frame_len = hs_mode ? (CW+1)'(FRAME_HS) : (CW+1)'(FRAME_FS);
  assign quarter   = frame_len >> 2;
  assign half      = frame_len >> 1;

  always_comb begin
    case (budget_sel)
      2'b01:   thresh = half;
      2'b10:   thresh = half + quarter;
      default: thresh = quarter;
    endcase
  end

  assign in_window = sg_mode && per_active && ({1'b0, elapsed} < thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (sof)
      elapsed <= '0;
    else if ({1'b0, elapsed} < frame_len - 1'b1)
      elapsed <= elapsed + 1'b1;
  end

  always_comb begin
    nxt_grant = G_NONE;
    if (burst_act)
      nxt_grant = grant;
    else if (!sg_mode) begin
      if (per_req && np_req) nxt_grant = np_last ? G_PER : G_NP;
      else if (per_req)      nxt_grant = G_PER;
      else if (np_req)       nxt_grant = G_NP;
    end else if (in_window) begin
      if (per_req)           nxt_grant = G_PER;
      else if (np_req)       nxt_grant = G_NP;
    end else begin
      if (np_req)            nxt_grant = G_NP;
      else if (per_req)      nxt_grant = G_PER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant   <= G_NONE;
      np_last <= 1'b1;
    end else begin
      grant <= nxt_grant;
      if (nxt_grant == G_NP)       np_last <= 1'b1;
      else if (nxt_grant == G_PER) np_last <= 1'b0;
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_act && !per_req && !np_req) |=> (grant == G_NONE));

  p_sof_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (elapsed == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act |=> $stable(grant));

  p_per_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && per_req && !burst_act) |=> (grant == G_PER));

  p_np_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_mode && !in_window && np_req && !burst_act) |=> (grant == G_NP));

endmodule

// File: tb/pdma_slice_arb_tb.sv
module pdma_slice_arb_tb_top;
  localparam int FHS = 40;
  localparam int FFS = 80;
  localparam int CW  = $clog2(FFS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, hs_mode = 1, sg_mode = 1, per_active = 1;
  logic per_req = 0, np_req = 0, burst_act = 0;
  logic [1:0] budget_sel = 2'b00;
  logic [1:0] grant;
  logic [CW-1:0] elapsed;
  logic in_window;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdma_slice_arb #(.FRAME_HS(FHS), .FRAME_FS(FFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .hs_mode(hs_mode),
    .budget_sel(budget_sel), .sg_mode(sg_mode), .per_active(per_active),
    .per_req(per_req), .np_req(np_req), .burst_act(burst_act),
    .grant(grant), .elapsed(elapsed), .in_window(in_window));

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sof();
    sof = 1; step(1); sof = 0;
  endtask

  task automatic t_reset();
    step(1);
    check("R1 grant in reset", grant, 0);
    check("R1 elapsed in reset", elapsed, 0);
    rst_n = 1; step(1);
    check("R1 grant after reset", grant, 0);
  endtask

  task automatic t_counter();
    per_req = 0; np_req = 0;
    hs_mode = 1; pulse_sof();
    check("R2 sof clears", elapsed, 0);
    step(25); check("R2 counting", elapsed, 25);
    pulse_sof(); check("R2 mid-frame restart", elapsed, 0);
    step(FHS + 5); check("R2 hs saturation", elapsed, FHS - 1);
    hs_mode = 0; pulse_sof();
    step(FFS + 5); check("R2 fs saturation", elapsed, FFS - 1);
  endtask

  task automatic t_budget(bit hs, logic [1:0] sel, int thr, string tag);
    hs_mode = hs; budget_sel = sel; sg_mode = 1; per_active = 1;
    per_req = 1; np_req = 1; burst_act = 0;
    pulse_sof(); step(thr);
    check({tag, " last periodic cycle"}, grant, 1);
    step(1);
    check({tag, " first non-periodic cycle"}, grant, 2);
  endtask

  task automatic t_work_conserving();
    hs_mode = 1; budget_sel = 2'b01; per_active = 1; sg_mode = 1;
    per_req = 0; np_req = 1; pulse_sof(); step(2);
    check("R5 np served in window when no periodic", grant, 2);
    per_req = 1; np_req = 0; step(30);
    check("R6 periodic served outside window when no np", grant, 1);
    np_req = 0; per_req = 0; step(1);
    check("R10 no request gives no grant", grant, 0);
  endtask

  task automatic t_no_periodic();
    hs_mode = 1; budget_sel = 2'b10; per_active = 0; sg_mode = 1;
    per_req = 1; np_req = 1; pulse_sof(); step(3);
    check("R7 np priority with no periodic endpoint", grant, 2);
    check("R7 window closed", in_window, 0);
    np_req = 0; step(1);
    check("R7 periodic served when np idle", grant, 1);
    per_active = 1;
  endtask

  task automatic t_round_robin();
    logic [1:0] a, b;
    sg_mode = 0; per_active = 1; budget_sel = 2'b10; hs_mode = 1;
    per_req = 1; np_req = 1; pulse_sof(); step(2);
    a = grant; step(1); b = grant;
    check("R8 alternation covers both classes", a | b, 3);
    check("R8 single grant", a ^ b, 3);
    step(1);
    check("R8 third decision repeats first", grant, a);
    sg_mode = 1;
  endtask

  task automatic t_burst();
    hs_mode = 1; budget_sel = 2'b00; sg_mode = 1; per_active = 1;
    per_req = 1; np_req = 1; burst_act = 0;
    pulse_sof(); step(8);
    check("R9 periodic before burst", grant, 1);
    burst_act = 1; step(6);
    check("R9 grant held past window", grant, 1);
    burst_act = 0; step(1);
    check("R9 switch after burst", grant, 2);
  endtask

  task automatic t_collision();
    hs_mode = 1; budget_sel = 2'b00; sg_mode = 1; per_active = 1;
    per_req = 1; np_req = 1; burst_act = 0;
    pulse_sof(); step(5);
    burst_act = 1; step(15);
    check("R9 held at count 20", grant, 1);
    burst_act = 0; pulse_sof();
    check("R6 release on sof edge uses old count", grant, 2);
    check("R2 count restarted", elapsed, 0);
    step(1);
    check("R5 periodic regains priority", grant, 1);
  endtask

  initial begin
    t_reset();
    t_counter();
    t_budget(1'b1, 2'b00, 10, "R3 hs 25%");
    t_budget(1'b1, 2'b01, 20, "R3 hs 50%");
    t_budget(1'b1, 2'b10, 30, "R3 hs 75%");
    t_budget(1'b0, 2'b10, 60, "R3 fs 75%");
    t_budget(1'b0, 2'b01, 40, "R3 fs 50%");
    t_budget(1'b1, 2'b11, 10, "R4 reserved code");
    t_work_conserving();
    t_no_periodic();
    t_round_robin();
    t_burst();
    t_collision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule